// File: doc/BRIEF.md
# Sectored Four-Way Cache Tag Array

This block holds the address tags, per-line coherence states and replacement state for a four-way set-associative cache of 1024 sets. Each way of a set holds one sector of two 32-byte lines. The two lines share one tag, and each line keeps its own 2-bit MESI state. A lookup presents a line address and gets back, one cycle later, a registered result: hit or miss, the hitting way, the state of the addressed line, and the way a refill should use. Fills write a line's state into a chosen way. When the stored tag differs, the fill also replaces the sector tag and drops the other line of that sector.

A debug port reads or writes one entry of the tag store: its tag, one line's state and the set's replacement bits. One control bit routes the access either to the tag side or to the data side. The data RAM lives outside this block, so data-side accesses leave the tag store alone. While a debug access is presented, the block holds off lookups and fills for that cycle.

Top module: `sect_tag_array`

## Requirements
- R1: A synchronous active-high reset sets every line to Invalid and every set's replacement bits to 000. After reset, rsp_valid and dbg_rvalid are low, acc_ready is high, and a first lookup misses with victim way 0.
- R2: For the 32-bit physical address, bit 5 picks the line inside the sector (0 = first line, 1 = second line), bits [15:6] pick the set, and bits [31:16] are the tag. Bits [4:0] are not ports of the block.
- R3: A lookup hits when some way's tag equals the address tag and the addressed line in that way is not Invalid. If several ways qualify, the lowest way is reported. On a miss, rsp_way is 0 and rsp_state is 00.
- R4: States are coded I=00, S=01, E=10, M=11. A fill stores fill_state into the addressed line, and a hit reports that line's stored code.
- R5: A lookup accepted in cycle n (lk_valid and acc_ready high at the edge) raises rsp_valid for cycle n+1 only, with the result in the same cycle.
- R6: Each set has three replacement bits. Bit 0 chooses the pair (0 = ways 0/1, 1 = ways 2/3). Bit 1 chooses within ways 0/1 (0 = way 0). Bit 2 chooses within ways 2/3 (0 = way 2). A hit or a fill on way w sets bit 0 to point at the other pair and sets that pair's bit to point at w's sibling.
- R7: rsp_victim is the lowest way in which both lines are Invalid. If there is no such way, it is the way chosen by the replacement bits. It is computed before that lookup's own update.
- R8: A fill whose tag differs from the chosen way's stored tag writes the new tag and makes the other line Invalid. A fill with an equal tag leaves the other line's state unchanged.
- R9: Debug control word layout: set in bits [9:0], way in [13:12], line in bit 16, tag-side select in bit 20 (1 = tag side). All other control bits must be zero. Write data and read data use the same layout: state in [1:0], tag in [17:2], replacement bits in [20:18]. A tag-side write sets all three fields. A read returns dbg_rvalid and the data in the next cycle.
- R10: A data-side debug access (bit 20 = 0) changes no tag, state or replacement bit, and a data-side read returns zero.
- R11: While dbg_valid is high, acc_ready is low. A lookup or fill presented in that cycle produces no response and no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_ready | output | 1 | Lookups and fills are accepted this cycle |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 27 | Lookup address bits [31:5] |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | 27 | Fill address bits [31:5] |
| fill_way | input | 2 | Way receiving the fill |
| fill_state | input | 2 | State written to the filled line |
| dbg_valid | input | 1 | Debug access request |
| dbg_write | input | 1 | 1 = debug write, 0 = debug read |
| dbg_ctrl | input | 21 | Debug control word (set, way, line, side select) |
| dbg_wdata | input | 21 | Debug write data (state, tag, replacement bits) |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Hitting way |
| rsp_state | output | 2 | State of the addressed line on a hit |
| rsp_victim | output | 2 | Way a refill should use |
| dbg_rvalid | output | 1 | Debug read data valid |
| dbg_rdata | output | 21 | Debug read data |

## Verification
Directed lookups cover several cases. One address is probed in both lines of its sector, which separates a tag match from a valid line. One probe flips only the set field, which separates set decoding from tag decoding. Sectors are filled one after another to walk the replacement tree and to show when empty ways take precedence over it. Fills with equal and with differing tags show whether the sibling line survives. Constrained random traffic then mixes lookups, fills, and tag-side and data-side debug accesses over a few sets and tags, including sets 0 and 1023. This makes hits, misses, evictions and tag collisions common. Debug accesses presented together with a lookup or a fill show whether the stall both drops the response and blocks the write.

// File: rtl/sect_tag_pkg.sv
package sect_tag_pkg;

    localparam int unsigned NWAYS  = 4;
    localparam int unsigned WAY_W  = 2;
    localparam int unsigned PLRU_W = 3;

    // debug control word field positions
    localparam int unsigned DBG_WAY_LO   = 12;
    localparam int unsigned DBG_LINE_BIT = 16;
    localparam int unsigned DBG_TSEL_BIT = 20;
    localparam int unsigned DBG_CTRL_W   = DBG_TSEL_BIT + 1;

    // debug data word field positions
    localparam int unsigned DBG_STATE_LO = 0;
    localparam int unsigned DBG_TAG_LO   = 2;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [PLRU_W-1:0] plru_t;

    typedef enum logic [1:0] {
        MESI_I = 2'b00,
        MESI_S = 2'b01,
        MESI_E = 2'b10,
        MESI_M = 2'b11
    } mesi_e;

    typedef struct packed {
        logic  hit;
        way_t  way;
        mesi_e state;
        way_t  victim;
    } lk_rsp_t;

    // move the tree away from the way just used
    function automatic plru_t plru_touch(plru_t cur, way_t w);
        plru_t nxt;
        nxt = cur;
        if (w[1] == 1'b0) begin
            nxt[0] = 1'b1;
            nxt[1] = ~w[0];
        end else begin
            nxt[0] = 1'b0;
            nxt[2] = ~w[0];
        end
        return nxt;
    endfunction

    function automatic way_t plru_pick(plru_t cur);
        way_t w;
        if (cur[0]) w = cur[2] ? 2'd3 : 2'd2;
        else        w = cur[1] ? 2'd1 : 2'd0;
        return w;
    endfunction

endpackage

// File: rtl/sect_way_match.sv
module sect_way_match
    import sect_tag_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NWAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [NWAYS-1:0][1:0][1:0]   way_st,
    input  logic [TAG_W-1:0]             probe_tag,
    input  logic                         probe_line,
    input  plru_t                        set_lru,
    output logic                         hit,
    output way_t                         hit_way,
    output mesi_e                        hit_state,
    output way_t                         victim
);

    logic [NWAYS-1:0] hit_vec;
    logic [NWAYS-1:0] empty_vec;

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        assign hit_vec[g]   = (way_tag[g] == probe_tag) &&
                              (way_st[g][probe_line] != MESI_I);
        assign empty_vec[g] = (way_st[g][0] == MESI_I) && (way_st[g][1] == MESI_I);
    end

    // lowest way wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit       = 1'b0;
        hit_way   = '0;
        hit_state = MESI_I;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit       = 1'b1;
                hit_way   = way_t'(w);
                hit_state = mesi_e'(way_st[w][probe_line]);
            end
        end
    end

    always_comb begin
        victim = plru_pick(set_lru);
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (empty_vec[w]) victim = way_t'(w);
        end
    end

    assert_hit_live_R3: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_state != MESI_I) && (way_tag[hit_way] == probe_tag));

    assert_victim_free_R7: assert property (@(posedge clk) disable iff (rst)
        (|empty_vec) |-> (way_st[victim] == '0));

endmodule

// File: rtl/sect_tag_store.sv
module sect_tag_store
    import sect_tag_pkg::*;
#(
    parameter int SETS  = 1024,
    parameter int TAG_W = 16,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic                         clk,
    input  logic                         rst,
    // lookup read port
    input  logic [SET_W-1:0]             ra_set,
    output logic [NWAYS-1:0][TAG_W-1:0]  ra_tag,
    output logic [NWAYS-1:0][1:0][1:0]   ra_st,
    output plru_t                        ra_lru,
    // fill / debug read port
    input  logic [SET_W-1:0]             rb_set,
    input  way_t                         rb_way,
    output logic [TAG_W-1:0]             rb_tag,
    output logic [1:0][1:0]              rb_st,
    output plru_t                        rb_lru,
    // entry write
    input  logic                         tag_we,
    input  logic                         st_we,
    input  logic                         sib_clr,
    input  logic [SET_W-1:0]             w_set,
    input  way_t                         w_way,
    input  logic                         w_line,
    input  logic [TAG_W-1:0]             w_tag,
    input  logic [1:0]                   w_st,
    // replacement write
    input  logic                         lru_we,
    input  logic [SET_W-1:0]             lru_set,
    input  plru_t                        lru_val
);

    logic [NWAYS-1:0][TAG_W-1:0] tag_mem [SETS];
    logic [NWAYS-1:0][1:0][1:0]  st_mem  [SETS];
    plru_t                       lru_mem [SETS];

    assign ra_tag = tag_mem[ra_set];
    assign ra_st  = st_mem[ra_set];
    assign ra_lru = lru_mem[ra_set];

    assign rb_tag = tag_mem[rb_set][rb_way];
    assign rb_st  = st_mem[rb_set][rb_way];
    assign rb_lru = lru_mem[rb_set];

    // tags carry no reset: an entry is only meaningful behind a valid state
    always_ff @(posedge clk) begin
        if (tag_we) tag_mem[w_set][w_way] <= w_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                st_mem[s]  <= '0;
                lru_mem[s] <= '0;
            end
        end else begin
            if (st_we) begin
                st_mem[w_set][w_way][w_line] <= w_st;
                if (sib_clr) st_mem[w_set][w_way][~w_line] <= MESI_I;
            end
            if (lru_we) lru_mem[lru_set] <= lru_val;
        end
    end

    assert_sibling_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (st_we && sib_clr) |=>
            (st_mem[$past(w_set)][$past(w_way)][~$past(w_line)] == MESI_I));

    assert_line_write_R4: assert property (@(posedge clk) disable iff (rst)
        st_we |=> (st_mem[$past(w_set)][$past(w_way)][$past(w_line)] == $past(w_st)));

endmodule

// File: rtl/sect_tag_array.sv
module sect_tag_array
    import sect_tag_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int SETS       = 1024,
    parameter  int LINE_BYTES = 32,
    localparam int LINE_BIT   = $clog2(LINE_BYTES),
    localparam int SET_LO     = LINE_BIT + 1,
    localparam int SET_W      = $clog2(SETS),
    localparam int TAG_LO     = SET_LO + SET_W,
    localparam int TAG_W      = ADDR_W - TAG_LO,
    localparam int DBG_LRU_LO = DBG_TAG_LO + TAG_W,
    localparam int DBG_DATA_W = DBG_LRU_LO + PLRU_W
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic                       acc_ready,
    input  logic                       lk_valid,
    input  logic [ADDR_W-1:LINE_BIT]   lk_addr,
    input  logic                       fill_valid,
    input  logic [ADDR_W-1:LINE_BIT]   fill_addr,
    input  logic [1:0]                 fill_way,
    input  logic [1:0]                 fill_state,
    input  logic                       dbg_valid,
    input  logic                       dbg_write,
    input  logic [DBG_CTRL_W-1:0]      dbg_ctrl,
    input  logic [DBG_DATA_W-1:0]      dbg_wdata,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic [1:0]                 rsp_way,
    output logic [1:0]                 rsp_state,
    output logic [1:0]                 rsp_victim,
    output logic                       dbg_rvalid,
    output logic [DBG_DATA_W-1:0]      dbg_rdata
);

    localparam logic [DBG_CTRL_W-1:0] DBG_USED =
        DBG_CTRL_W'((1 << SET_W) - 1) |
        DBG_CTRL_W'(3 << DBG_WAY_LO)  |
        DBG_CTRL_W'(1 << DBG_LINE_BIT) |
        DBG_CTRL_W'(1 << DBG_TSEL_BIT);

    // ---------------- address and control decode ----------------
    logic [SET_W-1:0] lk_set, fill_set, dbg_set;
    logic [TAG_W-1:0] lk_tag, fill_tag, dbg_tag;
    logic             lk_line, fill_line, dbg_line, dbg_tsel;
    way_t             dbg_way;
    logic [1:0]       dbg_st;
    plru_t            dbg_lru;

    assign lk_set    = lk_addr[SET_LO +: SET_W];
    assign lk_tag    = lk_addr[ADDR_W-1:TAG_LO];
    assign lk_line   = lk_addr[LINE_BIT];
    assign fill_set  = fill_addr[SET_LO +: SET_W];
    assign fill_tag  = fill_addr[ADDR_W-1:TAG_LO];
    assign fill_line = fill_addr[LINE_BIT];

    assign dbg_set   = dbg_ctrl[SET_W-1:0];
    assign dbg_way   = dbg_ctrl[DBG_WAY_LO +: WAY_W];
    assign dbg_line  = dbg_ctrl[DBG_LINE_BIT];
    assign dbg_tsel  = dbg_ctrl[DBG_TSEL_BIT];
    assign dbg_st    = dbg_wdata[DBG_STATE_LO +: 2];
    assign dbg_tag   = dbg_wdata[DBG_TAG_LO +: TAG_W];
    assign dbg_lru   = dbg_wdata[DBG_LRU_LO +: PLRU_W];

    // ---------------- acceptance ----------------
    logic lk_go, fill_go, dbg_tag_wr, dbg_rd;

    assign acc_ready  = ~dbg_valid;
    assign lk_go      = lk_valid & acc_ready;
    assign fill_go    = fill_valid & acc_ready;
    assign dbg_tag_wr = dbg_valid & dbg_write & dbg_tsel;
    assign dbg_rd     = dbg_valid & ~dbg_write;

    // ---------------- storage ----------------
    logic [NWAYS-1:0][TAG_W-1:0] ra_tag;
    logic [NWAYS-1:0][1:0][1:0]  ra_st;
    plru_t                       ra_lru;
    logic [SET_W-1:0]            rb_set;
    way_t                        rb_way;
    logic [TAG_W-1:0]            rb_tag;
    logic [1:0][1:0]             rb_st;
    plru_t                       rb_lru;

    logic             tag_we, st_we, sib_clr, w_line, lru_we;
    logic [SET_W-1:0] w_set, lru_set;
    way_t             w_way;
    logic [TAG_W-1:0] w_tag;
    logic [1:0]       w_st;
    plru_t            lru_val;

    // port B serves the debug entry when debug is active, else the fill entry
    assign rb_set = dbg_valid ? dbg_set : fill_set;
    assign rb_way = dbg_valid ? dbg_way : way_t'(fill_way);

    sect_tag_store #(
        .SETS  (SETS),
        .TAG_W (TAG_W),
        .SET_W (SET_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .ra_set  (lk_set),
        .ra_tag  (ra_tag),
        .ra_st   (ra_st),
        .ra_lru  (ra_lru),
        .rb_set  (rb_set),
        .rb_way  (rb_way),
        .rb_tag  (rb_tag),
        .rb_st   (rb_st),
        .rb_lru  (rb_lru),
        .tag_we  (tag_we),
        .st_we   (st_we),
        .sib_clr (sib_clr),
        .w_set   (w_set),
        .w_way   (w_way),
        .w_line  (w_line),
        .w_tag   (w_tag),
        .w_st    (w_st),
        .lru_we  (lru_we),
        .lru_set (lru_set),
        .lru_val (lru_val)
    );

    // ---------------- compare ----------------
    logic  m_hit;
    way_t  m_way, m_victim;
    mesi_e m_state;

    sect_way_match #(
        .TAG_W (TAG_W)
    ) u_match (
        .clk        (clk),
        .rst        (rst),
        .way_tag    (ra_tag),
        .way_st     (ra_st),
        .probe_tag  (lk_tag),
        .probe_line (lk_line),
        .set_lru    (ra_lru),
        .hit        (m_hit),
        .hit_way    (m_way),
        .hit_state  (m_state),
        .victim     (m_victim)
    );

    // ---------------- write steering ----------------
    logic fill_new_tag;

    // an empty sector takes the tag unconditionally; sibling is already Invalid
    assign fill_new_tag = (rb_tag != fill_tag) || (rb_st == '0);

    always_comb begin
        tag_we  = 1'b0;
        st_we   = 1'b0;
        sib_clr = 1'b0;
        w_set   = fill_set;
        w_way   = way_t'(fill_way);
        w_line  = fill_line;
        w_tag   = fill_tag;
        w_st    = fill_state;
        lru_we  = 1'b0;
        lru_set = lk_set;
        lru_val = plru_touch(ra_lru, m_way);
        if (dbg_tag_wr) begin
            tag_we  = 1'b1;
            st_we   = 1'b1;
            w_set   = dbg_set;
            w_way   = dbg_way;
            w_line  = dbg_line;
            w_tag   = dbg_tag;
            w_st    = dbg_st;
            lru_we  = 1'b1;
            lru_set = dbg_set;
            lru_val = dbg_lru;
        end else if (fill_go) begin
            tag_we  = fill_new_tag;
            st_we   = 1'b1;
            sib_clr = fill_new_tag;
            lru_we  = 1'b1;
            lru_set = fill_set;
            lru_val = plru_touch(rb_lru, way_t'(fill_way));
        end else if (lk_go && m_hit) begin
            lru_we  = 1'b1;
        end
    end

    // ---------------- registered results ----------------
    lk_rsp_t                 rsp_q;
    logic                    rsp_vq;
    logic                    drv_q;
    logic [DBG_DATA_W-1:0]   drd_q;
    logic [DBG_DATA_W-1:0]   dbg_pack;

    always_comb begin
        dbg_pack = '0;
        if (dbg_tsel) begin
            dbg_pack[DBG_STATE_LO +: 2]      = rb_st[dbg_line];
            dbg_pack[DBG_TAG_LO +: TAG_W]    = rb_tag;
            dbg_pack[DBG_LRU_LO +: PLRU_W]   = rb_lru;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q  <= '0;
            rsp_vq <= 1'b0;
            drv_q  <= 1'b0;
            drd_q  <= '0;
        end else begin
            rsp_vq <= lk_go;
            if (lk_go) begin
                rsp_q.hit    <= m_hit;
                rsp_q.way    <= m_hit ? m_way : '0;
                rsp_q.state  <= m_hit ? m_state : MESI_I;
                rsp_q.victim <= m_victim;
            end
            drv_q <= dbg_rd;
            if (dbg_rd) drd_q <= dbg_pack;
        end
    end

    assign rsp_valid  = rsp_vq;
    assign rsp_hit    = rsp_q.hit;
    assign rsp_way    = rsp_q.way;
    assign rsp_state  = rsp_q.state;
    assign rsp_victim = rsp_q.victim;
    assign dbg_rvalid = drv_q;
    assign dbg_rdata  = drd_q;

    // ---------------- port-level properties ----------------
    assert_miss_clean_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_state == 2'b00) && (rsp_way == 2'b00));

    assert_resp_next_R5: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !dbg_valid) |=> rsp_valid);

    assert_stall_drop_R11: assert property (@(posedge clk) disable iff (rst)
        dbg_valid |=> !rsp_valid);

    assert_dbg_read_R9: assert property (@(posedge clk) disable iff (rst)
        (dbg_valid && !dbg_write) |=> dbg_rvalid);

    assert_dbg_rsv_R9: assert property (@(posedge clk) disable iff (rst)
        dbg_valid |-> ((dbg_ctrl & ~DBG_USED) == '0));

    assert_data_side_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (dbg_valid && !dbg_write && !dbg_ctrl[DBG_TSEL_BIT]) |=> (dbg_rdata == '0));

endmodule

// File: tb/sect_tag_array_bench.sv
module sect_tag_array_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_ready;
    logic        lk_valid = 1'b0;
    logic [31:5] lk_addr = '0;
    logic        fill_valid = 1'b0;
    logic [31:5] fill_addr = '0;
    logic [1:0]  fill_way = '0;
    logic [1:0]  fill_state = '0;
    logic        dbg_valid = 1'b0;
    logic        dbg_write = 1'b0;
    logic [20:0] dbg_ctrl = '0;
    logic [20:0] dbg_wdata = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_way, rsp_state, rsp_victim;
    logic        dbg_rvalid;
    logic [20:0] dbg_rdata;

    always #5 clk = ~clk;

    sect_tag_array u_sect_tag_array (
        .clk(clk), .rst(rst), .acc_ready(acc_ready),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_way(fill_way), .fill_state(fill_state),
        .dbg_valid(dbg_valid), .dbg_write(dbg_write),
        .dbg_ctrl(dbg_ctrl), .dbg_wdata(dbg_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_state(rsp_state), .rsp_victim(rsp_victim),
        .dbg_rvalid(dbg_rvalid), .dbg_rdata(dbg_rdata)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // reference model
    logic [15:0] mtag [1024][4];
    logic [1:0]  mst  [1024][4][2];
    logic [2:0]  mlru [1024];
    bit          mwr  [1024][4];

    function automatic logic [2:0] m_touch(logic [2:0] l, int w);
        logic [2:0] r;
        r = l;
        if (w < 2) begin r[0] = 1'b1; r[1] = (w == 0); end
        else       begin r[0] = 1'b0; r[2] = (w == 2); end
        return r;
    endfunction

    function automatic int m_pick(logic [2:0] l);
        if (l[0]) return l[2] ? 3 : 2;
        return l[1] ? 1 : 0;
    endfunction

    function automatic logic [31:0] mk_addr(int tag, int set, int line, int low);
        return {tag[15:0], set[9:0], line[0], low[4:0]};
    endfunction

    function automatic logic [20:0] mk_ctrl(int set, int way, int line, int tsel);
        logic [20:0] c;
        c = '0;
        c[9:0]   = set[9:0];
        c[13:12] = way[1:0];
        c[16]    = line[0];
        c[20]    = tsel[0];
        return c;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_lookup(input logic [31:0] a);
        int set, line, ew, es, ev;
        logic [15:0] tg;
        bit eh;
        set = int'(a[15:6]); line = int'(a[5]); tg = a[31:16];
        eh = 1'b0; ew = 0; es = 0; ev = -1;
        for (int w = 0; w < 4; w++)
            if (!eh && mtag[set][w] == tg && mst[set][w][line] != 2'b00) begin
                eh = 1'b1; ew = w; es = int'(mst[set][w][line]);
            end
        for (int w = 0; w < 4; w++)
            if (ev < 0 && mst[set][w][0] == 2'b00 && mst[set][w][1] == 2'b00) ev = w;
        if (ev < 0) ev = m_pick(mlru[set]);
        lk_valid = 1'b1; lk_addr = a[31:5];
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R5", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R3", "rsp_hit", 32'(rsp_hit), 32'(eh));
        chk("R3", "rsp_way", 32'(rsp_way), 32'(ew));
        chk("R4", "rsp_state", 32'(rsp_state), 32'(es));
        chk("R7", "rsp_victim", 32'(rsp_victim), 32'(ev));
        if (eh) mlru[set] = m_touch(mlru[set], ew);
    endtask

    task automatic do_fill(input logic [31:0] a, input int way, input int st);
        int set, line;
        logic [15:0] tg;
        set = int'(a[15:6]); line = int'(a[5]); tg = a[31:16];
        fill_valid = 1'b1; fill_addr = a[31:5];
        fill_way = way[1:0]; fill_state = st[1:0];
        @(negedge clk);
        fill_valid = 1'b0;
        if (mtag[set][way] != tg) begin
            mtag[set][way] = tg;
            mst[set][way][1-line] = 2'b00;
        end
        mst[set][way][line] = st[1:0];
        mlru[set] = m_touch(mlru[set], way);
        mwr[set][way] = 1'b1;
    endtask

    task automatic dbg_rd(input int set, input int way, input int line, input int tsel);
        logic [20:0] e;
        dbg_valid = 1'b1; dbg_write = 1'b0; dbg_ctrl = mk_ctrl(set, way, line, tsel);
        @(negedge clk);
        dbg_valid = 1'b0;
        e = tsel ? {mlru[set], mtag[set][way], mst[set][way][line]} : 21'd0;
        chk("R9", "dbg_rvalid", 32'(dbg_rvalid), 32'd1);
        chk(tsel ? "R9" : "R10", "dbg_rdata", 32'(dbg_rdata), 32'(e));
        chk("R11", "rsp_valid during debug", 32'(rsp_valid), 32'd0);
    endtask

    task automatic dbg_wr(input int set, input int way, input int line, input int tsel,
                          input int tag, input int st, input int lru);
        dbg_valid = 1'b1; dbg_write = 1'b1; dbg_ctrl = mk_ctrl(set, way, line, tsel);
        dbg_wdata = {lru[2:0], tag[15:0], st[1:0]};
        @(negedge clk);
        dbg_valid = 1'b0; dbg_write = 1'b0;
        chk("R9", "dbg_rvalid on write", 32'(dbg_rvalid), 32'd0);
        if (tsel != 0) begin
            mtag[set][way] = tag[15:0];
            mst[set][way][line] = st[1:0];
            mlru[set] = lru[2:0];
            mwr[set][way] = 1'b1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sets[4];
        int tags[5];
        logic [31:0] a;
        sets = '{0, 5, 9, 1023};
        tags = '{16'h0001, 16'h0002, 16'hBEEF, 16'h1234, 16'h0000};
        for (int s = 0; s < 1024; s++) begin
            mlru[s] = '0;
            for (int w = 0; w < 4; w++) begin
                mtag[s][w] = '0; mwr[s][w] = 1'b0;
                mst[s][w][0] = '0; mst[s][w][1] = '0;
            end
        end
        void'($urandom(32'd1357));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state at the ports
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1", "dbg_rvalid after reset", 32'(dbg_rvalid), 32'd0);
        chk("R1", "acc_ready after reset", 32'(acc_ready), 32'd1);
        do_lookup(mk_addr(16'h00AA, 5, 0, 0));
        chk("R1", "first victim", 32'(rsp_victim), 32'd0);

        // R2 R3 R4: fill then probe both lines and the offset bits
        a = mk_addr(16'h1234, 5, 0, 3);
        do_fill(a, 0, 2);
        do_lookup(a);
        chk("R4", "exclusive code", 32'(rsp_state), 32'd2);
        do_lookup(mk_addr(16'h1234, 5, 1, 3));
        chk("R3", "other line invalid misses", 32'(rsp_hit), 32'd0);
        do_lookup(mk_addr(16'h1234, 5, 0, 31));
        chk("R2", "offset bits ignored", 32'(rsp_hit), 32'd1);
        do_lookup(mk_addr(16'h1234, 6, 0, 3));
        chk("R2", "set field decoded", 32'(rsp_hit), 32'd0);
        do_lookup(mk_addr(16'h4321, 5, 0, 3));
        chk("R7", "first empty way", 32'(rsp_victim), 32'd1);

        // R8: same-tag fill keeps sibling, new tag drops it
        do_fill(mk_addr(16'h1234, 5, 1, 0), 0, 1);
        do_lookup(a);
        chk("R8", "sibling kept", 32'(rsp_hit), 32'd1);
        do_fill(mk_addr(16'h5555, 5, 1, 0), 0, 3);
        do_lookup(a);
        chk("R8", "sibling dropped", 32'(rsp_hit), 32'd0);
        do_lookup(mk_addr(16'h5555, 5, 1, 0));
        chk("R4", "modified code", 32'(rsp_state), 32'd3);

        // R6: walk the tree in set 9
        for (int w = 0; w < 4; w++) do_fill(mk_addr(w + 1, 9, 0, 0), w, 1);
        do_lookup(mk_addr(16'h0009, 9, 0, 0));
        chk("R6", "victim after 0..3 fills", 32'(rsp_victim), 32'd0);
        do_lookup(mk_addr(16'h0002, 9, 0, 0));
        do_lookup(mk_addr(16'h0009, 9, 0, 0));
        chk("R6", "victim after hit on way 1", 32'(rsp_victim), 32'd2);

        // R9: debug tag-side write and read back
        dbg_wr(7, 2, 1, 1, 16'hABCD, 3, 5);
        dbg_rd(7, 2, 1, 1);
        chk("R9", "packed read", 32'(dbg_rdata), {11'd0, 3'd5, 16'hABCD, 2'd3});
        do_lookup(mk_addr(16'hABCD, 7, 1, 0));
        chk("R9", "written entry hits", 32'(rsp_hit), 32'd1);

        // R10: data-side accesses leave tag store untouched
        dbg_wr(5, 0, 1, 0, 16'hFFFF, 0, 7);
        dbg_rd(5, 0, 1, 1);
        dbg_rd(5, 0, 1, 0);
        chk("R10", "data-side read zero", 32'(dbg_rdata), 32'd0);

        // R11: lookup during debug is dropped
        dbg_valid = 1'b1; dbg_write = 1'b0; dbg_ctrl = mk_ctrl(5, 0, 1, 1);
        lk_valid = 1'b1; lk_addr = mk_addr(16'h5555, 5, 1, 0) >> 5;
        #1;
        chk("R11", "acc_ready low", 32'(acc_ready), 32'd0);
        @(negedge clk);
        dbg_valid = 1'b0; lk_valid = 1'b0;
        chk("R11", "no response", 32'(rsp_valid), 32'd0);
        chk("R9", "read with stall", 32'(dbg_rvalid), 32'd1);

        // R11: fill during debug is dropped
        dbg_valid = 1'b1; dbg_ctrl = mk_ctrl(6, 0, 0, 0);
        fill_valid = 1'b1; fill_addr = mk_addr(16'h7777, 6, 0, 0) >> 5;
        fill_way = 2'd1; fill_state = 2'd2;
        @(negedge clk);
        dbg_valid = 1'b0; fill_valid = 1'b0;
        do_lookup(mk_addr(16'h7777, 6, 0, 0));
        chk("R11", "fill blocked", 32'(rsp_hit), 32'd0);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int op, s, t, ln, w;
            op = int'($urandom_range(0, 99));
            s  = sets[$urandom_range(0, 3)];
            t  = tags[$urandom_range(0, 4)];
            ln = int'($urandom_range(0, 1));
            w  = int'($urandom_range(0, 3));
            a  = mk_addr(t, s, ln, int'($urandom_range(0, 31)));
            if (op < 45) begin
                do_lookup(a);
            end else if (op < 75) begin
                int v, st;
                v = -1;
                for (int k = 0; k < 4; k++)
                    if (v < 0 && mst[s][k][0] == 2'b00 && mst[s][k][1] == 2'b00) v = k;
                if (v < 0) v = m_pick(mlru[s]);
                st = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 3));
                do_fill(a, ($urandom_range(0, 9) < 7) ? v : w, st);
            end else if (op < 88) begin
                if (mwr[s][w]) dbg_rd(s, w, ln, 1);
                else do_lookup(a);
            end else if (op < 95) begin
                dbg_wr(s, w, ln, 1, t, int'($urandom_range(0, 3)), int'($urandom_range(0, 7)));
            end else if (op < 98) begin
                dbg_rd(s, w, ln, 0);
            end else begin
                dbg_wr(s, w, ln, 0, int'($urandom_range(0, 65535)), 3, 7);
            end
        end

        finish_run();
    end

endmodule